// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is one 8-bit timer channel. A small write port reaches two registers: a control register and a data register. The control register picks one of three behaviours. The channel can stay stopped. It can decrement once every N clock cycles, where N is one of seven fixed ratios, some of which are not powers of two. It can decrement once for each rising edge seen on an external event input. A separate control bit holds the output pin low.

The data register holds the reload value. When the counter sits at 1 and one more decrement arrives, it reloads from the data register. On that decrement it also raises a one-cycle timeout pulse for an interrupt controller and toggles the output pin. A data value of 0 stands for a full count of 256. The current count and the control register can be read at the ports.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset `count`, `ctrl`, `timeout` and `tmr_out` are all 0.
- R2: While `ctrl[2:0]` is 000 and `ctrl[3]` is 0 the channel is stopped, and `count` does not change except through a data write.
- R3: With `ctrl[3]`=0, codes 1 to 7 in `ctrl[2:0]` give one decrement every 4, 10, 16, 50, 64, 100 and 200 clock cycles, in that order. With reload value D the timeout period is D times that ratio.
- R4: With `ctrl[3]`=1 the counter decrements once per rising edge of `ext_evt`. The input passes through two synchronising flops, so a level first sampled high at clock edge k causes the decrement at edge k+2.
- R5: A decrement that finds `count` at 1 loads the reload value into `count`. It also drives `timeout` high for exactly the following cycle.
- R6: Each timeout toggles `tmr_out`. While `ctrl[4]` is 1, `tmr_out` is held at 0 and timeouts still occur.
- R7: A write with `wr_addr`=1 sets the reload value. It also loads `count` only when the channel is stopped. While the channel runs, the new value takes effect at the next reload.
- R8: A reload value of 0 gives 256 decrements between timeouts.
- R9: A control write that changes `ctrl[2:0]` restarts the prescaler from zero. A control write that keeps the same code leaves the prescale phase untouched.
- R10: A write with `wr_addr`=0 stores `wr_data[4:0]` into the control register, which is visible on `ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 the data register |
| wr_data | input | 8 | Write data |
| ext_evt | input | 1 | Asynchronous external event input |
| timeout | output | 1 | One-cycle pulse on each reload |
| tmr_out | output | 1 | Output pin, toggled on each timeout |
| count | output | 8 | Current counter value |
| ctrl | output | 5 | Control register contents |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` change only away from the rising clock edge and never carry X while reset is released. The bench drives all inputs on the falling edge, so every write is seen cleanly at a single rising edge. It holds each `ext_evt` level for at least two cycles, so the synchroniser cannot miss a pulse.

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
  parameter int W  = 8,
  parameter int PW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         ext_evt,
  output logic         timeout,
  output logic         tmr_out,
  output logic [W-1:0] count,
  output logic [4:0]   ctrl
);

  logic [4:0]    ctrl_q;
  logic [W-1:0]  reload_q, cnt_q;
  logic [PW-1:0] psc_q, limit;
  logic [2:0]    sync_q;
  logic          out_q, to_q;

  wire [2:0] code     = ctrl_q[2:0];
  wire       ext_mode = ctrl_q[3];
  wire       hold_low = ctrl_q[4];
  wire       running  = ext_mode | (code != 3'd0);
  wire       ctrl_wr  = wr_en & ~wr_addr;
  wire       data_wr  = wr_en & wr_addr;

  always_comb begin
    case (code)
      3'd1:    limit = PW'(3);
      3'd2:    limit = PW'(9);
      3'd3:    limit = PW'(15);
      3'd4:    limit = PW'(49);
      3'd5:    limit = PW'(63);
      3'd6:    limit = PW'(99);
      3'd7:    limit = PW'(199);
      default: limit = '0;
    endcase
  end

  wire psc_tick = ~ext_mode & (code != 3'd0) & (psc_q == limit);
  wire ev       = sync_q[1] & ~sync_q[2];
  wire dec      = ext_mode ? ev : psc_tick;
  wire wrap     = dec & (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      psc_q    <= '0;
      sync_q   <= '0;
      out_q    <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ext_evt};
      to_q   <= wrap;
      if (ctrl_wr) ctrl_q <= wr_data[4:0];
      if (data_wr) reload_q <= wr_data;

      if (ctrl_wr && wr_data[2:0] != code) psc_q <= '0;
      else if (ext_mode || code == 3'd0 || psc_tick) psc_q <= '0;
      else psc_q <= psc_q + 1'b1;

      if (data_wr && !running) cnt_q <= wr_data;
      else if (dec) cnt_q <= wrap ? reload_q : cnt_q - 1'b1;

      if (hold_low) out_q <= 1'b0;
      else if (wrap) out_q <= ~out_q;
    end
  end

  assign timeout = to_q;
  assign tmr_out = out_q;
  assign count   = cnt_q;
  assign ctrl    = ctrl_q;

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !data_wr) |=> cnt_q == $past(cnt_q));

  // R3
  psc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psc_q <= PW'(199));

  // R5
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> cnt_q == $past(reload_q));

  // R6
  toggle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> to_q);

  // R6
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_low |=> !out_q);

endmodule

// File: tb/prescaled_down_timer_bench.sv
module prescaled_down_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_addr = 1'b0, ext_evt = 1'b0;
  logic [7:0] wr_data = '0;
  logic timeout, tmr_out;
  logic [7:0] count;
  logic [4:0] ctrl;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  prescaled_down_timer u_prescaled_down_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_evt(ext_evt), .timeout(timeout), .tmr_out(tmr_out), .count(count), .ctrl(ctrl));

  always #4 clk = ~clk;

  // behavioural reference
  int m_ctrl, m_reload, m_cnt, m_elapsed, m_out, m_to;
  bit [2:0] m_s;
  int ratios [8] = '{0, 4, 10, 16, 50, 64, 100, 200};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_reload = 0; m_cnt = 0; m_elapsed = 0; m_out = 0; m_to = 0; m_s = '0;
    end else begin
      int code, nctrl;
      bit ext, dec, run;
      code = m_ctrl % 8;
      ext  = (m_ctrl / 8) % 2;
      run  = ext || code != 0;
      if (ext) dec = m_s[1] && !m_s[2];
      else if (code != 0) dec = (m_elapsed + 1 == ratios[code]);
      else dec = 0;
      nctrl = m_ctrl;
      if (wr_en && !wr_addr) nctrl = wr_data % 32;
      if (wr_en && !wr_addr && (wr_data % 8) != code) m_elapsed = 0;
      else if (ext || code == 0 || dec) m_elapsed = 0;
      else m_elapsed = m_elapsed + 1;
      m_to = dec && m_cnt == 1;
      if (m_ctrl >= 16) m_out = 0;
      else if (m_to) m_out = 1 - m_out;
      if (wr_en && wr_addr && !run) m_cnt = wr_data;
      else if (dec) m_cnt = (m_cnt == 1) ? m_reload : (m_cnt + 255) % 256;
      if (wr_en && wr_addr) m_reload = wr_data;
      m_ctrl = nctrl;
      m_s = {m_s[1:0], ext_evt};
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(count == m_cnt[7:0], "R3 count vs model", count, m_cnt);
      check(timeout == m_to[0], "R5 timeout vs model", timeout, m_to);
      check(tmr_out == m_out[0], "R6 tmr_out vs model", tmr_out, m_out);
      check(ctrl == m_ctrl[4:0], "R10 ctrl vs model", ctrl, m_ctrl);
    end
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(bit a, int d);
    wr_en = 1'b1; wr_addr = a; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!timeout && n < 3000);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    ext_evt = 1'b1; idle(2); ext_evt = 1'b0; idle(2);
  endtask

  initial begin
    int p, o;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(count == 0 && ctrl == 0 && !timeout && !tmr_out, "R1 reset state", count, 0);
    wr(1, 5);
    check(count == 5, "R7 stopped data write loads count", count, 5);
    idle(50);
    check(count == 5, "R2 stopped count holds", count, 5);
    wr(0, 5'b01000); wr(0, 0);
    check(ctrl == 0, "R10 ctrl readback", ctrl, 0);

    for (int c = 1; c < 8; c++) begin
      wr(0, 0); wr(1, 2); wr(0, c);
      check(ctrl == c, "R10 ctrl code readback", ctrl, c);
      wait_to(p); wait_to(p);
      check(p == 2 * ratios[c], "R3 period for prescale code", p, 2 * ratios[c]);
    end

    wr(0, 0); wr(1, 3); wr(0, 1);
    wait_to(p);
    o = tmr_out;
    idle(1);
    check(!timeout, "R5 timeout lasts one cycle", timeout, 0);
    wait_to(p);
    check(tmr_out == !o, "R6 toggle on timeout", tmr_out, !o);
    check(count == 3, "R5 reload value after timeout", count, 3);

    wr(1, 5);
    check(count != 5, "R7 running write leaves count", count, 5);
    wait_to(p); wait_to(p);
    check(p == 20, "R7 new reload used after next wrap", p, 20);

    idle(7); wr(0, 1); wait_to(p);
    wait_to(p);
    check(p == 20, "R9 same-code write keeps phase", p, 20);

    wr(0, 2); wait_to(p);
    wait_to(p);
    check(p == 50, "R9 code change restarts prescaler", p, 50);

    wr(0, 5'b10001); wr(1, 2);
    wait_to(p); wait_to(p);
    check(p == 8, "R6 timeouts continue while held low", p, 8);
    check(tmr_out == 0, "R6 output held low", tmr_out, 0);

    wr(0, 0); wr(1, 0);
    check(count == 0, "R8 zero data loads", count, 0);
    wr(0, 1);
    wait_to(p); wait_to(p);
    check(p == 1024, "R8 zero means 256 counts", p, 1024);

    wr(0, 0); wr(1, 3); wr(0, 5'b01000);
    pulse(); pulse();
    check(count == 1, "R4 external edges counted", count, 1);
    idle(10);
    check(count == 1, "R4 level without edge ignored", count, 1);
    ext_evt = 1'b1;
    idle(2);
    check(count == 1 && !timeout, "R4 two-flop latency before decrement", count, 1);
    @(negedge clk);
    check(timeout && count == 3, "R4 third edge reloads", count, 3);
    ext_evt = 1'b0;
    idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule